// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out, for a port of sixteen general-purpose pins, the value each pin presents on the input data word. Each pin's value depends on its configuration fields (direction, output driver type, pull resistor), the output data word, and the state of an external agent that may leave the pin unconnected or drive it to a level. Where none of these defines a level, the pin floats and its input bit keeps the value it already had.

The block also keeps the external connection state of every pin. It accepts or refuses each external drive request according to whether that request would fight the pin's own driver. When the configuration changes, it drops external drives that have become conflicts. It raises a one-cycle rise or fall pulse on any pin whose resolved input bit changes. A register front end or a pin model supplies the configuration and output data, and a test harness or pad model supplies the drive requests.

Top module: `gpio_level_resolver`

## Requirements
- R1: Pin n's direction field sits at `mode_i[2n+1:2n]`. The value 01 makes the pin an output, and 00, 10 and 11 all behave as an input.
- R2: An output pin whose `otype_i[n]` is 0 (push-pull), or whose `otype_i[n]` is 1 (open-drain) with `odata_i[n]` at 0, resolves to `odata_i[n]`.
- R3: An open-drain output pin with `odata_i[n]` at 1 resolves to 0 while it is externally driven low. Otherwise it resolves from its pull field `pull_i[2n+1:2n]`: 01 (pull-up) gives 1 and 10 (pull-down) gives 0. With neither, its input bit holds its previous value.
- R4: An input pin that is externally driven resolves to the driven level. An input pin that is unconnected resolves to 1 with pull-up and to 0 with pull-down. An unconnected input pin with no pull holds its previous input bit.
- R5: A drive strobe `drv_stb_i[n]` with level `drv_lvl_i[n]` connects the pin at that level. On an output pin the strobe is ignored unless the pin is open-drain and the level is 0.
- R6: A disconnect strobe `disc_stb_i` leaves every pin set in `disc_mask_i` unconnected. It wins over a drive strobe on the same pin in the same cycle.
- R7: An externally driven pin that becomes an output, after a change of direction or driver type, is made unconnected if it is push-pull or is driven high.
- R8: After reset, every pin is unconnected, every external high flag is clear, the input word is 0 and no edge pulse is raised.
- R9: `rise_o[n]` pulses for one cycle when input bit n goes from 0 to 1, and `fall_o[n]` pulses for one cycle when it goes from 1 to 0.
- R10: The input word, the edge pulses and the connection state reflect a change of any input one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2*NPINS | Direction field per pin, 01 = output |
| otype_i | input | NPINS | Driver type per pin, 1 = open-drain |
| pull_i | input | 2*NPINS | Pull field per pin, 01 = up, 10 = down |
| odata_i | input | NPINS | Output data word |
| drv_stb_i | input | NPINS | Per-pin external drive request |
| drv_lvl_i | input | NPINS | Requested external level per pin |
| disc_stb_i | input | 1 | Disconnect request strobe |
| disc_mask_i | input | NPINS | Pins to disconnect with the strobe |
| in_word_o | output | NPINS | Resolved input data word |
| ext_conn_o | output | NPINS | Pin is externally driven |
| ext_high_o | output | NPINS | Last accepted external level per pin |
| rise_o | output | NPINS | One-cycle rising event per pin |
| fall_o | output | NPINS | One-cycle falling event per pin |

## Verification
The hardest state to reach is a pin that is externally driven and, later, turns into a conflicting output. The port refuses that drive when the pin is already an output, so the stimulus first accepts the drive in a permitted configuration: either an input pin, or an open-drain output driven low. Only then does it switch the direction or the driver type. The hold-on-float rule also needs staging: a pull first sets a known bit, then the pull is removed, and the check confirms the bit stays put.

// File: rtl/gpio_res_pkg.sv
// Package: shared encodings and the decoded per-pin configuration type.
// Assumes: field encodings are fixed by the register front end.
package gpio_res_pkg;

    typedef enum logic [1:0] {
        DIR_IN   = 2'b00,
        DIR_OUT  = 2'b01,
        DIR_ALT  = 2'b10,
        DIR_ANA  = 2'b11
    } pin_dir_e;

    localparam logic [1:0] PULL_HI = 2'b01;
    localparam logic [1:0] PULL_LO = 2'b10;

    typedef struct packed {
        logic is_out;
        logic open_drain;
        logic pull_hi;
        logic pull_lo;
    } pin_cfg_t;

endpackage

// File: rtl/gpio_cfg_decode.sv
// Module: turns packed configuration fields into one decoded record per pin.
// Assumes: 2-bit direction and pull fields per pin, one driver-type bit per pin.
module gpio_cfg_decode
    import gpio_res_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic [2*NPINS-1:0]      mode_i,
    input  logic [NPINS-1:0]        otype_i,
    input  logic [2*NPINS-1:0]      pull_i,
    output pin_cfg_t [NPINS-1:0]    cfg_o
);

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        // Decode one pin's direction, driver and pull fields.
        always_comb begin
            cfg_o[n].is_out     = (mode_i[2*n +: 2] == DIR_OUT);
            cfg_o[n].open_drain = otype_i[n];
            cfg_o[n].pull_hi    = (pull_i[2*n +: 2] == PULL_HI);
            cfg_o[n].pull_lo    = (pull_i[2*n +: 2] == PULL_LO);
        end
    end

endmodule

// File: rtl/gpio_drive_tracker.sv
// Module: keeps each pin's external connection state and level flag.
// Applies accepted drives, then the disconnect mask, then drops conflicts
// with the current configuration. Exposes the next state combinationally
// so the resolver sees it in the same cycle.
// Assumes: synchronous active-low reset.
module gpio_drive_tracker
    import gpio_res_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  pin_cfg_t [NPINS-1:0]    cfg_i,
    input  logic [NPINS-1:0]        drv_stb_i,
    input  logic [NPINS-1:0]        drv_lvl_i,
    input  logic                    disc_stb_i,
    input  logic [NPINS-1:0]        disc_mask_i,
    output logic [NPINS-1:0]        conn_nx_o,
    output logic [NPINS-1:0]        high_nx_o,
    output logic [NPINS-1:0]        conn_q_o,
    output logic [NPINS-1:0]        high_q_o
);

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        logic accept;
        logic conn_l;
        logic high_l;

        // Compute one pin's next connection state and level flag.
        always_comb begin
            accept = drv_stb_i[n] &&
                     (!cfg_i[n].is_out || (cfg_i[n].open_drain && !drv_lvl_i[n]));
            conn_l = conn_q_o[n];
            high_l = high_q_o[n];
            if (accept) begin
                conn_l = 1'b1;
                high_l = drv_lvl_i[n];
            end
            if (disc_stb_i && disc_mask_i[n]) begin
                conn_l = 1'b0;
            end
            if (conn_l && cfg_i[n].is_out && (!cfg_i[n].open_drain || high_l)) begin
                conn_l = 1'b0;
            end
        end

        assign conn_nx_o[n] = conn_l;
        assign high_nx_o[n] = high_l;

        // R6: a masked disconnect leaves the pin unconnected next cycle.
        assert_disc_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (disc_stb_i && disc_mask_i[n]) |=> !conn_q_o[n]);

        // R5: a refused drive on an output pin never connects it.
        assert_refused_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_stb_i[n] && cfg_i[n].is_out &&
             !(cfg_i[n].open_drain && !drv_lvl_i[n])) |=> !$rose(conn_q_o[n]));
    end

    // Register the connection state; reset leaves all pins unconnected and low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q_o <= '0;
            high_q_o <= '0;
        end else begin
            conn_q_o <= conn_nx_o;
            high_q_o <= high_nx_o;
        end
    end

endmodule

// File: rtl/gpio_pin_resolve.sv
// Module: combinational level resolution per pin. Produces the next input
// word, and holds the previous bit where the pin floats.
// Assumes: connection state is the tracker's next state.
module gpio_pin_resolve
    import gpio_res_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  pin_cfg_t [NPINS-1:0]    cfg_i,
    input  logic [NPINS-1:0]        odata_i,
    input  logic [NPINS-1:0]        conn_i,
    input  logic [NPINS-1:0]        high_i,
    input  logic [NPINS-1:0]        prev_i,
    output logic [NPINS-1:0]        word_o
);

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        logic bit_l;

        // Pick the pin's level by priority; fall back to the held bit.
        always_comb begin
            bit_l = prev_i[n];
            if (cfg_i[n].is_out) begin
                if (!cfg_i[n].open_drain || !odata_i[n]) begin
                    bit_l = odata_i[n];
                end else if (conn_i[n] && !high_i[n]) begin
                    bit_l = 1'b0;
                end else if (cfg_i[n].pull_hi) begin
                    bit_l = 1'b1;
                end else if (cfg_i[n].pull_lo) begin
                    bit_l = 1'b0;
                end
            end else if (conn_i[n]) begin
                bit_l = high_i[n];
            end else if (cfg_i[n].pull_hi) begin
                bit_l = 1'b1;
            end else if (cfg_i[n].pull_lo) begin
                bit_l = 1'b0;
            end
        end

        assign word_o[n] = bit_l;
    end

endmodule

// File: rtl/gpio_edge_reg.sv
// Module: registers the resolved input word and derives per-pin edge pulses.
// Assumes: synchronous active-low reset; the word resets to all zeros.
module gpio_edge_reg #(
    parameter int NPINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPINS-1:0]    word_nx_i,
    output logic [NPINS-1:0]    word_q_o,
    output logic [NPINS-1:0]    rise_o,
    output logic [NPINS-1:0]    fall_o
);

    // Capture the new word and flag bits that changed in either direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q_o <= '0;
            rise_o   <= '0;
            fall_o   <= '0;
        end else begin
            word_q_o <= word_nx_i;
            rise_o   <= word_nx_i & ~word_q_o;
            fall_o   <= ~word_nx_i & word_q_o;
        end
    end

    for (genvar n = 0; n < NPINS; n++) begin : g_chk
        // R9: a rise pulse coincides with a 0-to-1 step of the word bit.
        assert_rise_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[n] |-> (word_q_o[n] && !$past(word_q_o[n])));
        // R9: a fall pulse coincides with a 1-to-0 step of the word bit.
        assert_fall_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
            fall_o[n] |-> (!word_q_o[n] && $past(word_q_o[n])));
    end

endmodule

// File: rtl/gpio_level_resolver.sv
// Module: top of the pin level resolver. Decodes configuration, tracks
// external drives, resolves each pin and registers the word and edges.
// Assumes: one clock of latency from any input to every output.
module gpio_level_resolver
    import gpio_res_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*NPINS-1:0]      mode_i,
    input  logic [NPINS-1:0]        otype_i,
    input  logic [2*NPINS-1:0]      pull_i,
    input  logic [NPINS-1:0]        odata_i,
    input  logic [NPINS-1:0]        drv_stb_i,
    input  logic [NPINS-1:0]        drv_lvl_i,
    input  logic                    disc_stb_i,
    input  logic [NPINS-1:0]        disc_mask_i,
    output logic [NPINS-1:0]        in_word_o,
    output logic [NPINS-1:0]        ext_conn_o,
    output logic [NPINS-1:0]        ext_high_o,
    output logic [NPINS-1:0]        rise_o,
    output logic [NPINS-1:0]        fall_o
);

    pin_cfg_t [NPINS-1:0]   cfg;
    logic [NPINS-1:0]       conn_nx;
    logic [NPINS-1:0]       high_nx;
    logic [NPINS-1:0]       word_nx;

    gpio_cfg_decode #(.NPINS(NPINS)) u_dec (
        .mode_i  (mode_i),
        .otype_i (otype_i),
        .pull_i  (pull_i),
        .cfg_o   (cfg)
    );

    gpio_drive_tracker #(.NPINS(NPINS)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .drv_stb_i   (drv_stb_i),
        .drv_lvl_i   (drv_lvl_i),
        .disc_stb_i  (disc_stb_i),
        .disc_mask_i (disc_mask_i),
        .conn_nx_o   (conn_nx),
        .high_nx_o   (high_nx),
        .conn_q_o    (ext_conn_o),
        .high_q_o    (ext_high_o)
    );

    gpio_pin_resolve #(.NPINS(NPINS)) u_res (
        .cfg_i   (cfg),
        .odata_i (odata_i),
        .conn_i  (conn_nx),
        .high_i  (high_nx),
        .prev_i  (in_word_o),
        .word_o  (word_nx)
    );

    gpio_edge_reg #(.NPINS(NPINS)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_nx_i (word_nx),
        .word_q_o  (in_word_o),
        .rise_o    (rise_o),
        .fall_o    (fall_o)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_chk
        // R2: a push-pull output shows its output data one clock later.
        assert_pushpull_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[n].is_out && !cfg[n].open_drain) |=> (in_word_o[n] == $past(odata_i[n])));
        // R4: an accepted drive on an input pin shows its level one clock later.
        assert_input_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_stb_i[n] && !cfg[n].is_out && !(disc_stb_i && disc_mask_i[n]))
            |=> (in_word_o[n] == $past(drv_lvl_i[n])));
    end

endmodule

// File: tb/sim_gpio_level_resolver.sv
module sim_gpio_level_resolver;

    localparam int N = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] mode = '0;
    logic [N-1:0]   otype = '0;
    logic [2*N-1:0] pull = '0;
    logic [N-1:0]   odata = '0;
    logic [N-1:0]   dstb = '0;
    logic [N-1:0]   dlvl = '0;
    logic           xstb = 1'b0;
    logic [N-1:0]   xmask = '0;
    logic [N-1:0]   in_word, conn, high, rise, fall;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_level_resolver #(.NPINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .otype_i(otype), .pull_i(pull),
        .odata_i(odata), .drv_stb_i(dstb), .drv_lvl_i(dlvl), .disc_stb_i(xstb),
        .disc_mask_i(xmask), .in_word_o(in_word), .ext_conn_o(conn),
        .ext_high_o(high), .rise_o(rise), .fall_o(fall)
    );

    task automatic chk(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp, input logic [N-1:0] msk);
        checks++;
        if ((act & msk) !== (exp & msk)) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h mask=%h", req, act & msk, exp & msk, msk);
        end
    endtask

    // One clock: inputs presented at negedge register at posedge, strobes drop.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        dstb = '0;
        xstb = 1'b0;
        xmask = '0;
    endtask

    function automatic logic [N-1:0] b(input int n);
        return N'(1) << n;
    endfunction

    task automatic set_mode(input int n, input logic [1:0] v);
        mode[2*n +: 2] = v;
    endtask

    task automatic set_pull(input int n, input logic [1:0] v);
        pull[2*n +: 2] = v;
    endtask

    task automatic drive(input int n, input logic lv);
        dstb[n] = 1'b1;
        dlvl[n] = lv;
    endtask

    task automatic t_reset();
        chk("R8 word", in_word, '0, '1);
        chk("R8 conn", conn, '0, '1);
        chk("R8 high", high, '0, '1);
        chk("R8 edges", rise | fall, '0, '1);
    endtask

    task automatic t_pushpull();
        for (int n = 0; n < 4; n++) set_mode(n, 2'b01);
        odata = 16'h0005;
        tick();
        chk("R2 pushpull word", in_word, 16'h0005, 16'h000F);
        chk("R9 rise on 0,2", rise, 16'h0005, '1);
        chk("R10 fall quiet", fall, '0, '1);
        tick();
        chk("R9 single cycle pulse", rise, '0, '1);
    endtask

    task automatic t_reject();
        drive(1, 1'b1);
        drive(0, 1'b0);
        tick();
        chk("R5 reject conn", conn, '0, 16'h0003);
        chk("R5 reject word", in_word, 16'h0005, 16'h000F);
    endtask

    task automatic t_input_drive();
        drive(8, 1'b1);
        tick();
        chk("R4 driven high", in_word, b(8), b(8));
        chk("R5 conn accepted", conn, b(8), b(8));
        chk("R10 high flag", high, b(8), b(8));
        chk("R9 rise pin8", rise, b(8), '1);
        drive(8, 1'b0);
        tick();
        chk("R4 driven low", in_word, '0, b(8));
        chk("R9 fall pin8", fall, b(8), '1);
    endtask

    task automatic t_pull_float();
        set_pull(8, 2'b01);
        xstb = 1'b1;
        xmask = b(8);
        tick();
        chk("R6 disc pin8", conn, '0, b(8));
        chk("R4 pull up", in_word, b(8), b(8));
        set_pull(8, 2'b10);
        tick();
        chk("R4 pull down", in_word, '0, b(8));
        set_pull(8, 2'b01);
        tick();
        set_pull(8, 2'b00);
        tick();
        chk("R4 float holds 1", in_word, b(8), b(8));
        chk("R9 no edge on float", rise | fall, '0, b(8));
        drive(9, 1'b1);
        xstb = 1'b1;
        xmask = b(9);
        tick();
        chk("R6 disc beats drive conn", conn, '0, b(9));
        chk("R6 disc beats drive word", in_word, '0, b(9));
    endtask

    task automatic t_alt_modes();
        set_mode(10, 2'b10);
        drive(10, 1'b1);
        set_mode(11, 2'b11);
        set_pull(11, 2'b01);
        tick();
        chk("R1 mode10 as input", in_word, b(10), b(10));
        chk("R1 mode10 conn", conn, b(10), b(10));
        chk("R1 mode11 pull", in_word, b(11), b(11));
    endtask

    task automatic t_open_drain();
        set_mode(4, 2'b01);
        otype[4] = 1'b1;
        odata[4] = 1'b1;
        set_pull(4, 2'b01);
        tick();
        chk("R3 od pull up", in_word, b(4), b(4));
        set_pull(4, 2'b10);
        tick();
        chk("R3 od pull down", in_word, '0, b(4));
        set_pull(4, 2'b00);
        tick();
        chk("R3 od float holds 0", in_word, '0, b(4));
        set_pull(4, 2'b01);
        tick();
        drive(4, 1'b0);
        tick();
        chk("R3 od driven low", in_word, '0, b(4));
        chk("R5 od low accepted", conn, b(4), b(4));
        drive(4, 1'b1);
        tick();
        chk("R5 od high refused conn", conn, b(4), b(4));
        chk("R5 od high refused flag", high, '0, b(4));
        chk("R5 od high refused word", in_word, '0, b(4));
        odata[4] = 1'b0;
        tick();
        chk("R2 od data 0", in_word, '0, b(4));
        odata[4] = 1'b1;
        tick();
    endtask

    task automatic t_forced();
        otype[4] = 1'b0;
        tick();
        chk("R7 type change drops", conn, '0, b(4));
        chk("R7 pushpull word", in_word, b(4), b(4));
        set_mode(10, 2'b01);
        tick();
        chk("R7 dir change drops", conn, '0, b(10));
        chk("R7 fall pin10", fall, b(10), b(10));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pushpull();
        t_reject();
        t_input_drive();
        t_pull_float();
        t_alt_modes();
        t_open_drain();
        t_forced();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule